// File: doc/BRIEF.md
# Reset and Power-Down Controller

This block produces the single synchronized reset and the power-state controls of a small 8-bit microcontroller. It can raise a reset from four places: an active-low external reset pin, an active-low hardware power-down pin, a watchdog-timer timeout pulse, and an oscillator-failure pulse. The oscillator-failure pulse only counts when its enable input is high. Both pins pass through a synchronizer. They are then sampled once per machine cycle, at each `cycle_tick`. A short low on the power-down pin acts as a reset. A longer low puts the device into hardware power-down, in which the pin drivers are released.

A strap pin sets the power-save policy. While the strap is low, software may request slow-down, idle or power-down. While it is high, every such request is ignored. The strap level seen during reset also decides whether the watchdog starts by itself once the reset ends. Idle and slow-down end when an enabled interrupt arrives. Software power-down ends only through a reset.

Top module: `rstpwr_ctrl`

## Requirements
- R1: The reset pin, sampled low at two consecutive machine-cycle ticks, asserts `rst_out` right after the second of those ticks. A low seen at one tick only does not.
- R2: The power-down pin, sampled low at two consecutive ticks, asserts `rst_out` with `pin_float` still low.
- R3: The power-down pin, sampled low at three consecutive ticks, asserts `pin_float` together with `rst_out`. `pin_float` clears at the first tick that samples the pin high.
- R4: A one-clock `wdt_timeout` pulse asserts `rst_out` on the next clock edge.
- R5: A one-clock `osc_fail` pulse asserts `rst_out` on the next clock edge when `osc_wd_en` is high. When `osc_wd_en` is low, the pulse has no effect.
- R6: Once the last reset source is gone, `rst_out` stays high through two further ticks. It falls at the second of them.
- R7: With `psave_pin_n` low, a `pm_req_vld` strobe moves `pm_mode` from run on the next edge. The request codes are 01 slow-down, 10 idle and 11 power-down. Code 00 leaves the mode in run. `pm_mode` uses the same encoding, with 00 meaning run.
- R8: With `psave_pin_n` high, every power-mode request leaves `pm_mode` at 00.
- R9: From slow-down or idle, `irq_wake` returns `pm_mode` to 00 on the next edge. Software power-down ignores `irq_wake`. Any reset returns `pm_mode` to 00.
- R10: `wdt_auto_en` takes the synchronized strap level while `rst_out` is high. It holds that level after the reset ends, whatever the strap does later.
- R11: After `por_n` is released, the outputs are `rst_out`=1, `pin_float`=0, `pm_mode`=00 and `wdt_auto_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| cycle_tick | input | 1 | One-clock strobe at each machine-cycle boundary |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| hwpd_pin_n | input | 1 | Hardware power-down pin, active low, asynchronous |
| psave_pin_n | input | 1 | Power-save strap: low enables software power modes |
| wdt_timeout | input | 1 | Watchdog-timer reset request pulse |
| osc_fail | input | 1 | Oscillator-watchdog reset request pulse |
| osc_wd_en | input | 1 | Enable for oscillator-watchdog requests |
| pm_req_vld | input | 1 | Strobe for a software power-mode request |
| pm_req_code | input | 2 | Requested mode: 00 none, 01 slow, 10 idle, 11 power-down |
| irq_wake | input | 1 | Enabled interrupt pending |
| rst_out | output | 1 | Synchronized merged reset, active high |
| pin_float | output | 1 | Hardware power-down: release all pin drivers |
| pm_mode | output | 2 | Current power mode, same encoding as the request |
| wdt_auto_en | output | 1 | Watchdog starts automatically after reset |

## Verification
The bench drives the pins low for exactly one, two and three machine cycles. A qualifier with an off-by-one error would then either reset on a glitch or float the pins one cycle early. It counts the ticks after every release, so a stretch that is too short or too long shows up as `rst_out` falling at the wrong tick. It also checks that software power-down survives an interrupt while idle does not, that a blocked strap or a disabled oscillator watchdog changes nothing at the outputs, and that the autostart setting does not follow the strap once reset is over.

// File: rtl/rstpwr_pkg.sv
package rstpwr_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'b00,
      PM_SLOW = 2'b01,
      PM_IDLE = 2'b10,
      PM_PD   = 2'b11
   } pm_mode_e;
endpackage

// File: rtl/rstpwr_sync.sv
module rstpwr_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [63:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) stage_q[s] <= RST_VAL[WIDTH-1:0];
            else if (s == 0) stage_q[s] <= d_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstpwr_pin_qual.sv
module rstpwr_pin_qual #(
   parameter int SHORT_TICKS = 2,
   parameter int LONG_TICKS  = 3
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick_i,
   input  logic pin_s_i,
   output logic short_o,
   output logic long_o
);
   localparam int CW = $clog2(LONG_TICKS + 1);
   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) low_cnt <= '0;
      else if (tick_i) begin
         if (pin_s_i) low_cnt <= '0;
         else if (low_cnt != CW'(LONG_TICKS)) low_cnt <= low_cnt + 1'b1;
      end
   end

   assign short_o = (low_cnt >= CW'(SHORT_TICKS));
   assign long_o  = (low_cnt >= CW'(LONG_TICKS));
endmodule

// File: rtl/rstpwr_hold.sv
module rstpwr_hold #(
   parameter int HOLD_TICKS = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick_i,
   input  logic src_i,
   output logic rst_o
);
   localparam int HW = $clog2(HOLD_TICKS + 1);
   logic [HW-1:0] hold_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) hold_cnt <= HW'(HOLD_TICKS);
      else if (src_i) hold_cnt <= HW'(HOLD_TICKS);
      else if (tick_i && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
   end

   assign rst_o = src_i | (hold_cnt != '0);
endmodule

// File: rtl/rstpwr_pm_fsm.sv
module rstpwr_pm_fsm
   import rstpwr_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_i,
   input  logic       psave_s_i,
   input  logic       req_vld_i,
   input  logic [1:0] req_code_i,
   input  logic       wake_i,
   output logic [1:0] mode_o
);
   pm_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (rst_i) mode_d = PM_RUN;
      else begin
         unique case (mode_q)
            PM_RUN:  if (req_vld_i && !psave_s_i) mode_d = pm_mode_e'(req_code_i);
            PM_SLOW,
            PM_IDLE: if (wake_i) mode_d = PM_RUN;
            PM_PD:   mode_d = PM_PD;
            default: mode_d = PM_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) mode_q <= PM_RUN;
      else mode_q <= mode_d;
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/rstpwr_ctrl.sv
module rstpwr_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int RST_TICKS   = 2,
   parameter int PD_TICKS    = 3,
   parameter int HOLD_TICKS  = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       cycle_tick,
   input  logic       rst_pin_n,
   input  logic       hwpd_pin_n,
   input  logic       psave_pin_n,
   input  logic       wdt_timeout,
   input  logic       osc_fail,
   input  logic       osc_wd_en,
   input  logic       pm_req_vld,
   input  logic [1:0] pm_req_code,
   input  logic       irq_wake,
   output logic       rst_out,
   output logic       pin_float,
   output logic [1:0] pm_mode,
   output logic       wdt_auto_en
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2");
      assert (RST_TICKS >= 1) else $error("RST_TICKS below 1");
      assert (PD_TICKS > RST_TICKS) else $error("PD_TICKS must exceed RST_TICKS");
      assert (HOLD_TICKS >= 1) else $error("HOLD_TICKS below 1");
   end

   logic [2:0] pins_s;
   logic       rst_s, hwpd_s, psave_s;

   rstpwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d_i   ({psave_pin_n, hwpd_pin_n, rst_pin_n}),
      .q_o   (pins_s)
   );
   assign rst_s   = pins_s[0];
   assign hwpd_s  = pins_s[1];
   assign psave_s = pins_s[2];

   logic ext_short, ext_long, pd_short, pd_long;

   rstpwr_pin_qual #(.SHORT_TICKS(RST_TICKS), .LONG_TICKS(RST_TICKS)) u_ext_qual (
      .clk (clk), .por_n (por_n), .tick_i (cycle_tick), .pin_s_i (rst_s),
      .short_o (ext_short), .long_o (ext_long)
   );

   rstpwr_pin_qual #(.SHORT_TICKS(RST_TICKS), .LONG_TICKS(PD_TICKS)) u_pd_qual (
      .clk (clk), .por_n (por_n), .tick_i (cycle_tick), .pin_s_i (hwpd_s),
      .short_o (pd_short), .long_o (pd_long)
   );

   logic wdt_q, osc_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wdt_q <= 1'b0;
         osc_q <= 1'b0;
      end else begin
         wdt_q <= wdt_timeout;
         osc_q <= osc_fail & osc_wd_en;
      end
   end

   logic any_src;
   assign any_src = ext_short | ext_long | pd_short | wdt_q | osc_q;

   rstpwr_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk (clk), .por_n (por_n), .tick_i (cycle_tick),
      .src_i (any_src), .rst_o (rst_out)
   );

   assign pin_float = pd_long;

   rstpwr_pm_fsm u_pm (
      .clk        (clk),
      .por_n      (por_n),
      .rst_i      (rst_out),
      .psave_s_i  (psave_s),
      .req_vld_i  (pm_req_vld),
      .req_code_i (pm_req_code),
      .wake_i     (irq_wake),
      .mode_o     (pm_mode)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) wdt_auto_en <= 1'b1;
      else if (rst_out) wdt_auto_en <= psave_s;
   end
endmodule

// File: rtl/rstpwr_ctrl_chk.sv
module rstpwr_ctrl_chk (
   input logic       clk,
   input logic       por_n,
   input logic       wdt_timeout,
   input logic       osc_fail,
   input logic       osc_wd_en,
   input logic       pm_req_vld,
   input logic       irq_wake,
   input logic       psave_s,
   input logic       rst_out,
   input logic       pin_float,
   input logic [1:0] pm_mode,
   input logic       wdt_auto_en
);
   a_r4_wdt_resets: assert property (@(posedge clk) disable iff (!por_n)
      wdt_timeout |=> rst_out);

   a_r5_osc_resets: assert property (@(posedge clk) disable iff (!por_n)
      (osc_fail && osc_wd_en) |=> rst_out);

   a_r3_float_in_reset: assert property (@(posedge clk) disable iff (!por_n)
      pin_float |-> rst_out);

   a_r9_pd_sticky: assert property (@(posedge clk) disable iff (!por_n)
      (pm_mode == 2'b11 && !rst_out) |=> (pm_mode == 2'b11));

   a_r9_wake_leaves: assert property (@(posedge clk) disable iff (!por_n)
      ((pm_mode == 2'b01 || pm_mode == 2'b10) && irq_wake && !rst_out) |=> (pm_mode == 2'b00));

   a_r8_blocked: assert property (@(posedge clk) disable iff (!por_n)
      (pm_mode == 2'b00 && pm_req_vld && psave_s) |=> (pm_mode == 2'b00));

   a_r10_auto_stable: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_out && $past(!rst_out)) |-> $stable(wdt_auto_en));

   a_r9_reset_to_run: assert property (@(posedge clk) disable iff (!por_n)
      rst_out |=> (pm_mode == 2'b00));
endmodule

bind rstpwr_ctrl rstpwr_ctrl_chk chk_i (
   .clk         (clk),
   .por_n       (por_n),
   .wdt_timeout (wdt_timeout),
   .osc_fail    (osc_fail),
   .osc_wd_en   (osc_wd_en),
   .pm_req_vld  (pm_req_vld),
   .irq_wake    (irq_wake),
   .psave_s     (psave_s),
   .rst_out     (rst_out),
   .pin_float   (pin_float),
   .pm_mode     (pm_mode),
   .wdt_auto_en (wdt_auto_en)
);

// File: tb/rstpwr_ctrl_tb.sv
`timescale 1ns/1ps
module rstpwr_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       por_n, cycle_tick, rst_pin_n, hwpd_pin_n, psave_pin_n;
   logic       wdt_timeout, osc_fail, osc_wd_en, pm_req_vld, irq_wake;
   logic [1:0] pm_req_code;
   logic       rst_out, pin_float, wdt_auto_en;
   logic [1:0] pm_mode;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   rstpwr_ctrl dut_i (
      .clk (clk), .por_n (por_n), .cycle_tick (cycle_tick),
      .rst_pin_n (rst_pin_n), .hwpd_pin_n (hwpd_pin_n), .psave_pin_n (psave_pin_n),
      .wdt_timeout (wdt_timeout), .osc_fail (osc_fail), .osc_wd_en (osc_wd_en),
      .pm_req_vld (pm_req_vld), .pm_req_code (pm_req_code), .irq_wake (irq_wake),
      .rst_out (rst_out), .pin_float (pin_float), .pm_mode (pm_mode),
      .wdt_auto_en (wdt_auto_en)
   );

   // {psave_pin_n, code[1:0], wake, exp_after_req[1:0], exp_after_wake[1:0]}
   localparam logic [7:0] VEC [8] = '{
      {1'b0, 2'b01, 1'b1, 2'b01, 2'b00},
      {1'b0, 2'b10, 1'b1, 2'b10, 2'b00},
      {1'b0, 2'b11, 1'b1, 2'b11, 2'b11},
      {1'b0, 2'b00, 1'b0, 2'b00, 2'b00},
      {1'b1, 2'b01, 1'b0, 2'b00, 2'b00},
      {1'b1, 2'b10, 1'b0, 2'b00, 2'b00},
      {1'b1, 2'b11, 1'b0, 2'b00, 2'b00},
      {1'b0, 2'b10, 1'b0, 2'b10, 2'b10}
   };

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one machine cycle: 11 plain clocks, then a clock with the tick
   task automatic mc(input int n);
      repeat (n) begin
         clks(11);
         cycle_tick = 1'b1;
         clks(1);
         cycle_tick = 1'b0;
      end
   endtask

   task automatic pulse_wdt();
      wdt_timeout = 1'b1;
      clks(1);
      wdt_timeout = 1'b0;
   endtask

   task automatic full_reset();
      pulse_wdt();
      mc(2);
      clks(1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected finish");
         report();
      end
   end

   initial begin
      por_n = 1'b0; cycle_tick = 1'b0; rst_pin_n = 1'b1; hwpd_pin_n = 1'b1;
      psave_pin_n = 1'b1; wdt_timeout = 1'b0; osc_fail = 1'b0; osc_wd_en = 1'b1;
      pm_req_vld = 1'b0; pm_req_code = 2'b00; irq_wake = 1'b0;
      clks(3);
      por_n = 1'b1;
      clks(1);
      // R11 reset state
      check("R11 rst_out", {1'b0, rst_out}, 2'b01);
      check("R11 pin_float", {1'b0, pin_float}, 2'b00);
      check("R11 pm_mode", pm_mode, 2'b00);
      check("R11 wdt_auto_en", {1'b0, wdt_auto_en}, 2'b01);
      mc(1);
      check("R6 hold after por, 1 tick", {1'b0, rst_out}, 2'b01);
      mc(1);
      check("R6 release after por, 2 ticks", {1'b0, rst_out}, 2'b00);

      // R1 reset pin
      rst_pin_n = 1'b0;
      mc(1);
      check("R1 one sample ignored", {1'b0, rst_out}, 2'b00);
      mc(1);
      check("R1 two samples reset", {1'b0, rst_out}, 2'b01);
      rst_pin_n = 1'b1;
      mc(2);
      check("R6 still held", {1'b0, rst_out}, 2'b01);
      mc(1);
      check("R6 released", {1'b0, rst_out}, 2'b00);

      // R2 short power-down pulse
      hwpd_pin_n = 1'b0;
      mc(2);
      check("R2 reset", {1'b0, rst_out}, 2'b01);
      check("R2 no float", {1'b0, pin_float}, 2'b00);
      hwpd_pin_n = 1'b1;
      mc(3);
      check("R2 released", {1'b0, rst_out}, 2'b00);

      // R3 long power-down
      hwpd_pin_n = 1'b0;
      mc(3);
      check("R3 float", {1'b0, pin_float}, 2'b01);
      check("R3 reset", {1'b0, rst_out}, 2'b01);
      hwpd_pin_n = 1'b1;
      mc(1);
      check("R3 float cleared", {1'b0, pin_float}, 2'b00);
      check("R3 reset held", {1'b0, rst_out}, 2'b01);
      mc(2);
      check("R3 released", {1'b0, rst_out}, 2'b00);

      // R4 watchdog timeout
      pulse_wdt();
      check("R4 next edge", {1'b0, rst_out}, 2'b01);
      mc(1);
      check("R6 wdt hold 1", {1'b0, rst_out}, 2'b01);
      mc(1);
      check("R6 wdt release", {1'b0, rst_out}, 2'b00);

      // R5 oscillator watchdog
      osc_fail = 1'b1; clks(1); osc_fail = 1'b0;
      check("R5 enabled resets", {1'b0, rst_out}, 2'b01);
      mc(2);
      check("R5 released", {1'b0, rst_out}, 2'b00);
      osc_wd_en = 1'b0;
      osc_fail = 1'b1; clks(1); osc_fail = 1'b0;
      check("R5 disabled ignored", {1'b0, rst_out}, 2'b00);
      mc(1);
      check("R5 disabled still quiet", {1'b0, rst_out}, 2'b00);

      // R10 autostart capture
      psave_pin_n = 1'b0;
      clks(3);
      full_reset();
      check("R10 captured low", {1'b0, wdt_auto_en}, 2'b00);
      psave_pin_n = 1'b1;
      clks(4);
      check("R10 ignores later strap", {1'b0, wdt_auto_en}, 2'b00);

      // table of power-mode requests
      for (int i = 0; i < 8; i++) begin
         psave_pin_n = VEC[i][7];
         clks(3);
         pm_req_code = VEC[i][6:5];
         pm_req_vld  = 1'b1;
         clks(1);
         pm_req_vld  = 1'b0;
         check(VEC[i][7] ? "R8 request blocked" : "R7 request taken", pm_mode, VEC[i][3:2]);
         if (VEC[i][4]) begin
            irq_wake = 1'b1; clks(1); irq_wake = 1'b0;
            check("R9 wake", pm_mode, VEC[i][1:0]);
         end
         if (pm_mode != 2'b00) begin
            full_reset();
            check("R9 reset to run", pm_mode, 2'b00);
         end
      end

      // R9 idle left by external reset pin
      psave_pin_n = 1'b0;
      clks(3);
      pm_req_code = 2'b10; pm_req_vld = 1'b1; clks(1); pm_req_vld = 1'b0;
      check("R7 idle entered", pm_mode, 2'b10);
      rst_pin_n = 1'b0;
      mc(2);
      clks(1);
      check("R9 pin reset leaves idle", pm_mode, 2'b00);
      rst_pin_n = 1'b1;
      mc(3);
      check("R10 captured low again", {1'b0, wdt_auto_en}, 2'b00);

      done = 1'b1;
      report();
   end
endmodule